// File: doc/BRIEF.md
# Differential Sensor-Row Configuration Loader

This block turns rows read from a two-dimensional light-sensor array into configuration lines for a small reconfigurable logic fabric. Each sensor row carries one brightness bit per pixel, and neighbouring pixels form complementary pairs. Every pair yields one configuration bit, so a 64-pixel row becomes a 32-bit line. Two pair states are illegal: both pixels lit, and both pixels dark. An external comparator-noise vector stands in for the value a fully dark pair settles to.

A page of 64 rows holds four complete fabric images of thirteen lines each. After a start strobe the loader latches the chosen image slot. It then fetches the thirteen rows of that slot one at a time through a request/acknowledge row port, and the sensor side may answer each request after any number of cycles. Each decoded line goes out as a single-cycle write tagged with its fabric target. The first eight targets feed the four lookup cells, two lines each, and the last five feed the interconnect matrices. A one-cycle done pulse closes the sequence.

Top module: `cfg_page_loader`

## Requirements
- R1: Pair j of a row is made of pixel 2j (first) and pixel 2j+1 (second) of `pix_i`, where 1 means lit. The pair dark-then-lit gives line bit j = 1, and the pair lit-then-dark gives bit j = 0.
- R2: A lit-lit pair decodes to 0.
- R3: A dark-dark pair decodes to bit j of `flick_i`, sampled in the cycle the row is acknowledged.
- R4: `wr_bad_o` is 1 with a write exactly when at least one pair of that line was lit-lit or dark-dark.
- R5: The n-th row fetched after a start (n = 0..12) has address 13*s + n, where s is the value of `slot_i` sampled with the accepted start.
- R6: `row_req_o` stays high with a stable `row_addr_o` until a cycle in which `row_ack_i` is high. The acknowledge may come in the first request cycle or any later one.
- R7: One cycle after the acknowledging cycle, `wr_o` pulses for one cycle and carries the decoded line. Pixel or noise values that arrive after the acknowledge do not change the written data.
- R8: Writes come in target order 0 to 12 on `wr_tgt_o`. Target t < 8 is lookup cell t/2, line t%2. Target t >= 8 is interconnect matrix t-8.
- R9: `done_o` pulses for exactly one cycle, in the cycle after the write with target 12.
- R10: A start strobe is ignored while `busy_o` is high, which covers every cycle from the one after an accepted start through the done cycle. The slot value given with an ignored strobe has no effect on the addresses fetched.
- R11: After reset, `row_req_o`, `wr_o`, `done_o` and `busy_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load start strobe |
| slot_i | input | 2 | Image slot within the page |
| row_req_o | output | 1 | Row fetch request |
| row_addr_o | output | 6 | Row being requested |
| row_ack_i | input | 1 | Row sample valid |
| pix_i | input | 64 | Per-pixel brightness of the row, 1 = lit |
| flick_i | input | 32 | Comparator noise used for dark-dark pairs |
| wr_o | output | 1 | Line write strobe |
| wr_tgt_o | output | 4 | Fabric target index of the write |
| wr_data_o | output | 32 | Decoded configuration line |
| wr_bad_o | output | 1 | Line contained an illegal pair |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Load finished pulse |

## Verification
The hardest case to reach from the ports is a dark-dark pair, because its result depends on noise that must be sampled in exactly the acknowledging cycle. The sensor model in the bench builds page rows that mix all four pair kinds, and it redraws the noise vector and the pixel bus every cycle. Data that is captured early or late therefore shows up as a mismatch on bit groups kept apart by pair kind. Acknowledge latency is drawn at random from zero to three cycles. Start strobes carrying a different slot are injected both in the middle of a load and in the done cycle.

// File: rtl/clp_pkg.sv
package clp_pkg;

    localparam int DEF_ROW_PIX   = 64;
    localparam int DEF_ROWS      = 64;
    localparam int DEF_CFG_LINES = 13;
    localparam int DEF_CFG_SLOTS = 4;

    // loader phases
    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_FETCH = 2'd1,
        LD_WRITE = 2'd2,
        LD_DONE  = 2'd3
    } ld_state_e;

    // kinds of pixel pair
    typedef enum logic [1:0] {
        PR_ONE  = 2'd0,  // dark then lit
        PR_ZERO = 2'd1,  // lit then dark
        PR_SAT  = 2'd2,  // both lit
        PR_DARK = 2'd3   // both dark
    } pair_e;

    typedef struct packed {
        logic  bit_v;
        logic  bad;
    } pair_res_t;

    function automatic pair_e pair_class(input logic first, input logic second);
        pair_e k;
        case ({first, second})
            2'b01:   k = PR_ONE;
            2'b10:   k = PR_ZERO;
            2'b11:   k = PR_SAT;
            default: k = PR_DARK;
        endcase
        return k;
    endfunction

    function automatic pair_res_t pair_decode(input pair_e k, input logic noise);
        pair_res_t r;
        case (k)
            PR_ONE:  begin r.bit_v = 1'b1;  r.bad = 1'b0; end
            PR_ZERO: begin r.bit_v = 1'b0;  r.bad = 1'b0; end
            PR_SAT:  begin r.bit_v = 1'b0;  r.bad = 1'b1; end
            default: begin r.bit_v = noise; r.bad = 1'b1; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/clp_pair_dec.sv
module clp_pair_dec
    import clp_pkg::*;
(
    input  logic first_i,
    input  logic second_i,
    input  logic noise_i,
    output logic bit_o,
    output logic bad_o
);
    pair_e     kind;
    pair_res_t res;

    always_comb begin
        kind  = pair_class(first_i, second_i);
        res   = pair_decode(kind, noise_i);
        bit_o = res.bit_v;
        bad_o = res.bad;
    end
endmodule

// File: rtl/clp_row_dec.sv
module clp_row_dec #(
    parameter int ROW_PIX = 64,
    localparam int PAIRS  = ROW_PIX / 2
) (
    input  logic [ROW_PIX-1:0] pix_i,
    input  logic [PAIRS-1:0]   noise_i,
    output logic [PAIRS-1:0]   line_o,
    output logic               bad_o
);
    logic [PAIRS-1:0] bad_vec;

    for (genvar j = 0; j < PAIRS; j++) begin : g_pair
        clp_pair_dec u_pair (
            .first_i  (pix_i[2*j]),
            .second_i (pix_i[2*j+1]),
            .noise_i  (noise_i[j]),
            .bit_o    (line_o[j]),
            .bad_o    (bad_vec[j])
        );
    end

    assign bad_o = |bad_vec;
endmodule

// File: rtl/clp_line_latch.sv
module clp_line_latch #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_i,
    input  logic [W-1:0] line_i,
    input  logic         bad_i,
    output logic [W-1:0] line_o,
    output logic         bad_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            line_o <= '0;
            bad_o  <= 1'b0;
        end else if (cap_i) begin
            line_o <= line_i;
            bad_o  <= bad_i;
        end
    end
endmodule

// File: rtl/clp_seq.sv
module clp_seq
    import clp_pkg::*;
#(
    parameter int ROWS      = 64,
    parameter int CFG_LINES = 13,
    parameter int CFG_SLOTS = 4,
    localparam int ROW_AW   = $clog2(ROWS),
    localparam int SLOT_W   = $clog2(CFG_SLOTS),
    localparam int TGT_W    = $clog2(CFG_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              row_ack_i,
    output logic              row_req_o,
    output logic [ROW_AW-1:0] row_addr_o,
    output logic              cap_o,
    output logic              wr_o,
    output logic [TGT_W-1:0]  tgt_o,
    output logic              done_o,
    output logic              busy_o
);
    localparam logic [TGT_W-1:0] LAST_LINE = TGT_W'(CFG_LINES - 1);

    ld_state_e         state_q;
    logic [TGT_W-1:0]  line_q;
    logic [ROW_AW-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LD_IDLE;
            line_q  <= '0;
            base_q  <= '0;
        end else begin
            case (state_q)
                LD_IDLE: begin
                    if (start_i) begin
                        base_q  <= ROW_AW'(slot_i) * ROW_AW'(CFG_LINES);
                        line_q  <= '0;
                        state_q <= LD_FETCH;
                    end
                end
                LD_FETCH: begin
                    if (row_ack_i) state_q <= LD_WRITE;
                end
                LD_WRITE: begin
                    if (line_q == LAST_LINE) begin
                        state_q <= LD_DONE;
                    end else begin
                        line_q  <= line_q + 1'b1;
                        state_q <= LD_FETCH;
                    end
                end
                default: state_q <= LD_IDLE;
            endcase
        end
    end

    always_comb begin
        row_req_o  = (state_q == LD_FETCH);
        row_addr_o = base_q + ROW_AW'(line_q);
        cap_o      = row_req_o & row_ack_i;
        wr_o       = (state_q == LD_WRITE);
        tgt_o      = line_q;
        done_o     = (state_q == LD_DONE);
        busy_o     = (state_q != LD_IDLE);
    end
endmodule

// File: rtl/cfg_page_loader.sv
module cfg_page_loader
    import clp_pkg::*;
#(
    parameter int ROW_PIX   = DEF_ROW_PIX,
    parameter int ROWS      = DEF_ROWS,
    parameter int CFG_LINES = DEF_CFG_LINES,
    parameter int CFG_SLOTS = DEF_CFG_SLOTS,
    localparam int PAIRS    = ROW_PIX / 2,
    localparam int ROW_AW   = $clog2(ROWS),
    localparam int SLOT_W   = $clog2(CFG_SLOTS),
    localparam int TGT_W    = $clog2(CFG_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic              row_req_o,
    output logic [ROW_AW-1:0] row_addr_o,
    input  logic              row_ack_i,
    input  logic [ROW_PIX-1:0] pix_i,
    input  logic [PAIRS-1:0]  flick_i,
    output logic              wr_o,
    output logic [TGT_W-1:0]  wr_tgt_o,
    output logic [PAIRS-1:0]  wr_data_o,
    output logic              wr_bad_o,
    output logic              busy_o,
    output logic              done_o
);
    logic             cap;
    logic [PAIRS-1:0] dec_line;
    logic             dec_bad;

    clp_seq #(
        .ROWS      (ROWS),
        .CFG_LINES (CFG_LINES),
        .CFG_SLOTS (CFG_SLOTS)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .slot_i     (slot_i),
        .row_ack_i  (row_ack_i),
        .row_req_o  (row_req_o),
        .row_addr_o (row_addr_o),
        .cap_o      (cap),
        .wr_o       (wr_o),
        .tgt_o      (wr_tgt_o),
        .done_o     (done_o),
        .busy_o     (busy_o)
    );

    clp_row_dec #(
        .ROW_PIX (ROW_PIX)
    ) u_dec (
        .pix_i   (pix_i),
        .noise_i (flick_i),
        .line_o  (dec_line),
        .bad_o   (dec_bad)
    );

    clp_line_latch #(
        .W (PAIRS)
    ) u_latch (
        .clk    (clk),
        .rst    (rst),
        .cap_i  (cap),
        .line_i (dec_line),
        .bad_i  (dec_bad),
        .line_o (wr_data_o),
        .bad_o  (wr_bad_o)
    );
endmodule

// File: rtl/cfg_page_loader_chk.sv
module cfg_page_loader_chk #(
    parameter int ROW_AW    = 6,
    parameter int TGT_W     = 4,
    parameter int CFG_LINES = 13,
    parameter int CFG_SLOTS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              row_req_o,
    input logic [ROW_AW-1:0] row_addr_o,
    input logic              row_ack_i,
    input logic              wr_o,
    input logic [TGT_W-1:0]  wr_tgt_o,
    input logic              busy_o,
    input logic              done_o
);
    a_r6_hold_request: assert property (@(posedge clk) disable iff (rst)
        (row_req_o && !row_ack_i) |=> (row_req_o && $stable(row_addr_o)));

    a_r7_write_follows_ack: assert property (@(posedge clk) disable iff (rst)
        (row_req_o && row_ack_i) |=> wr_o);

    a_r7_write_single: assert property (@(posedge clk) disable iff (rst)
        wr_o |=> !wr_o);

    a_r8_target_range: assert property (@(posedge clk) disable iff (rst)
        wr_o |-> (int'(wr_tgt_o) < CFG_LINES));

    a_r5_addr_range: assert property (@(posedge clk) disable iff (rst)
        row_req_o |-> (int'(row_addr_o) < CFG_LINES * CFG_SLOTS));

    a_r9_done_after_last: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(wr_o) && int'($past(wr_tgt_o)) == CFG_LINES - 1));

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r10_busy_covers: assert property (@(posedge clk) disable iff (rst)
        (row_req_o || wr_o || done_o) |-> busy_o);
endmodule

bind cfg_page_loader cfg_page_loader_chk #(
    .ROW_AW    (ROW_AW),
    .TGT_W     (TGT_W),
    .CFG_LINES (CFG_LINES),
    .CFG_SLOTS (CFG_SLOTS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .row_req_o  (row_req_o),
    .row_addr_o (row_addr_o),
    .row_ack_i  (row_ack_i),
    .wr_o       (wr_o),
    .wr_tgt_o   (wr_tgt_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/sim_cfg_page_loader.sv
`timescale 1ns/1ps
module sim_cfg_page_loader;
    localparam int NPIX  = 64;
    localparam int NPAIR = 32;
    localparam int NLINE = 13;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [1:0]        slot_i = '0;
    logic              row_req_o;
    logic [5:0]        row_addr_o;
    logic              row_ack_i = 1'b0;
    logic [NPIX-1:0]   pix_i = '0;
    logic [NPAIR-1:0]  flick_i = '0;
    logic              wr_o;
    logic [3:0]        wr_tgt_o;
    logic [NPAIR-1:0]  wr_data_o;
    logic              wr_bad_o;
    logic              busy_o;
    logic              done_o;

    cfg_page_loader u0 (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int bad    = 0;
    int cyc    = 0;
    bit finished = 0;

    logic [NPIX-1:0] page [64];

    // reference model state
    int              m_st = 0;   // 0 idle, 1 fetch, 2 write, 3 done
    int              m_line = 0;
    int              m_slot = 0;
    logic [NPAIR-1:0] m_data, m_vmask, m_smask, m_dmask;
    logic             m_bad;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NPIX-1:0] make_row(input int r);
        logic [NPIX-1:0] v = '0;
        for (int j = 0; j < NPAIR; j++) begin
            int k = (r % 3 == 0) ? int'($urandom % 2) :
                    (r % 3 == 1) ? int'($urandom % 3) : int'($urandom % 4);
            case (k)
                0: begin v[2*j] = 1'b0; v[2*j+1] = 1'b1; end
                1: begin v[2*j] = 1'b1; v[2*j+1] = 1'b0; end
                2: begin v[2*j] = 1'b1; v[2*j+1] = 1'b1; end
                default: begin v[2*j] = 1'b0; v[2*j+1] = 1'b0; end
            endcase
        end
        return v;
    endfunction

    // sensor model: random acknowledge latency, bus garbage otherwise
    int wait_n = -1;
    always @(negedge clk) begin
        if (!rst && row_req_o) begin
            if (wait_n < 0) wait_n = int'($urandom % 4);
            if (wait_n == 0) begin
                row_ack_i <= 1'b1;
                pix_i     <= page[row_addr_o];
                wait_n    = -1;
            end else begin
                wait_n--;
                row_ack_i <= 1'b0;
                pix_i     <= {$urandom, $urandom};
            end
        end else begin
            row_ack_i <= 1'b0;
            pix_i     <= {$urandom, $urandom};
        end
        flick_i <= $urandom;
    end

    // reference model
    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_line = 0; m_slot = 0;
        end else begin
            case (m_st)
                0: if (start_i) begin m_slot = int'(slot_i); m_line = 0; m_st = 1; end
                1: if (row_ack_i) begin
                    m_bad = 1'b0;
                    for (int j = 0; j < NPAIR; j++) begin
                        m_vmask[j] = 1'b0; m_smask[j] = 1'b0; m_dmask[j] = 1'b0;
                        if (!pix_i[2*j] && pix_i[2*j+1]) begin
                            m_data[j] = 1'b1; m_vmask[j] = 1'b1;
                        end else if (pix_i[2*j] && !pix_i[2*j+1]) begin
                            m_data[j] = 1'b0; m_vmask[j] = 1'b1;
                        end else if (pix_i[2*j]) begin
                            m_data[j] = 1'b0; m_smask[j] = 1'b1; m_bad = 1'b1;
                        end else begin
                            m_data[j] = flick_i[j]; m_dmask[j] = 1'b1; m_bad = 1'b1;
                        end
                    end
                    m_st = 2;
                end
                2: if (m_line == NLINE - 1) m_st = 3; else begin m_line++; m_st = 1; end
                default: m_st = 0;
            endcase
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(busy_o == (m_st != 0), "R10", "busy", busy_o, m_st != 0);
            chk(row_req_o == (m_st == 1), "R6", "row_req", row_req_o, m_st == 1);
            if (m_st == 1)
                chk(int'(row_addr_o) == m_slot * NLINE + m_line, "R5", "row_addr",
                    row_addr_o, m_slot * NLINE + m_line);
            chk(wr_o == (m_st == 2), "R7", "wr", wr_o, m_st == 2);
            if (m_st == 2 && wr_o) begin
                chk(int'(wr_tgt_o) == m_line, "R8", "target", wr_tgt_o, m_line);
                chk(((wr_data_o ^ m_data) & m_vmask) == '0, "R1", "valid pairs",
                    wr_data_o & m_vmask, m_data & m_vmask);
                chk(((wr_data_o ^ m_data) & m_smask) == '0, "R2", "lit-lit pairs",
                    wr_data_o & m_smask, m_data & m_smask);
                chk(((wr_data_o ^ m_data) & m_dmask) == '0, "R3", "dark-dark pairs",
                    wr_data_o & m_dmask, m_data & m_dmask);
                chk(wr_bad_o == m_bad, "R4", "bad flag", wr_bad_o, m_bad);
            end
            chk(done_o == (m_st == 3), "R9", "done", done_o, m_st == 3);
        end
    end

    task automatic finish_run();
        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    task automatic wait_idle();
        int n = 0;
        while (m_st != 0 && n < 2000) begin @(negedge clk); n++; end
    endtask

    // intrude: 0 none, 1 start mid-load, 2 start in done cycle
    task automatic load(input int s, input int intrude);
        @(negedge clk);
        start_i = 1'b1; slot_i = 2'(s);
        @(negedge clk);
        start_i = 1'b0;
        if (intrude == 1) begin
            repeat (9) @(negedge clk);
            start_i = 1'b1; slot_i = 2'(s + 1);   // R10: must be ignored
            @(negedge clk);
            start_i = 1'b0;
        end
        if (intrude == 2) begin
            while (m_st != 3) @(negedge clk);
            start_i = 1'b1; slot_i = 2'(s + 2);   // R10: done cycle, ignored
            @(negedge clk);
            start_i = 1'b0;
        end
        wait_idle();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        for (int r = 0; r < 64; r++) page[r] = make_row(r);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk(!row_req_o && !wr_o && !done_o && !busy_o, "R11", "reset outputs",
            {row_req_o, wr_o, done_o, busy_o}, 0);
        rst = 1'b0;
        load(0, 0);
        load(1, 1);
        load(2, 2);
        load(3, 1);
        for (int r = 0; r < 64; r++) page[r] = make_row(r + 1);
        load(3, 0);
        load(0, 2);
        load(2, 0);
        finish_run();
    end
endmodule